// File: doc/BRIEF.md
# Single-Precision Sign-Injection and Register Move Unit

This combinational unit sits beside a floating-point register file whose entries are 64 bits wide but hold 32-bit single-precision values. It performs the three sign-injection operations: copy the sign, copy the inverted sign, and XOR the signs. When both source register indices are equal, these become move, negate and absolute value. It also performs the raw bit moves from an integer register into a float register and from a float register into an integer register.

In normal mode, a 32-bit value is legal only when it sits in the low half of the 64-bit register with the upper half all ones. An operand without that boxing is replaced by the boxed canonical quiet NaN (0xFFFFFFFF_7FC00000) before any sign operation uses it. In integer-register mode, floating-point values live in integer registers. That mode skips the box check and sign-extends every result from bit 31. A dirty strobe flags results that are written into floating-point state.

Top module: `fp_sign_move`

## Requirements
- R1: In normal mode (`int_mode`=0), a source of a sign operation whose bits 63:32 are not all ones is replaced by 0xFFFFFFFF_7FC00000 before use.
- R2: Sign-inject (`op`=0, `same_reg`=0) returns bits 30:0 of the first checked operand, and bits 63:31 of the second checked operand.
- R3: Sign-inject-negate (`op`=1, `same_reg`=0) returns the first checked operand with bit 31 replaced by the inverse of the second operand's bit 31.
- R4: Sign-inject-xor (`op`=2, `same_reg`=0) returns the first checked operand with bit 31 set to the XOR of both operands' bit 31.
- R5: With `same_reg`=1, the result uses the first checked operand only. Op 0 returns it unchanged, op 1 returns it with bit 31 flipped, and op 2 returns it with bit 31 cleared.
- R6: In integer-register mode (`int_mode`=1), no box check is made. Every result of ops 0 to 3 is bits 31:0 of the computed value, sign-extended from bit 31.
- R7: Integer-to-float move (`op`=3) in normal mode returns {32'hFFFFFFFF, src_a[31:0]}.
- R8: Float-to-integer move (`op`=4) returns src_a[31:0] sign-extended from bit 31, with no box check, in either mode.
- R9: `fp_dirty` is 1 for ops 0 to 3 and 0 for op 4.
- R10: Op codes 5 to 7 return a zero result with `fp_dirty`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | First source register value |
| src_b | input | 64 | Second source register value |
| op | input | 3 | 0 inject, 1 inject-negate, 2 inject-xor, 3 int-to-float move, 4 float-to-int move |
| same_reg | input | 1 | Both source register indices are equal |
| int_mode | input | 1 | 1 selects integer-register mode |
| result | output | 64 | Value to write back |
| fp_dirty | output | 1 | Result writes floating-point state |

## Verification
The unit holds no state. A wrong box decision or a wrong sign selection therefore shows on `result` in the same cycle the inputs settle. Unboxed operands are paired with sign sources of the opposite polarity, so that a missed NaN substitution or a sign taken from the wrong operand changes visible bits. In integer-register mode, results with both sign values are checked, so that boxing used in place of sign extension shows up in the upper word.

// File: rtl/fp_sign_move.sv
module fp_sign_move (
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [2:0]  op,
  input  logic        same_reg,
  input  logic        int_mode,
  output logic [63:0] result,
  output logic        fp_dirty
);
  localparam logic [2:0] OP_INJ  = 3'd0;
  localparam logic [2:0] OP_INJN = 3'd1;
  localparam logic [2:0] OP_INJX = 3'd2;
  localparam logic [2:0] OP_I2F  = 3'd3;
  localparam logic [2:0] OP_F2I  = 3'd4;
  localparam logic [63:0] QNAN_BOXED = 64'hFFFF_FFFF_7FC0_0000;

  logic [63:0] opa, opb, raw;
  logic        writes_fp;

  assign opa = (int_mode || (&src_a[63:32])) ? src_a : QNAN_BOXED;
  assign opb = (int_mode || (&src_b[63:32])) ? src_b : QNAN_BOXED;

  always_comb begin
    raw = '0;
    writes_fp = 1'b1;
    case (op)
      OP_INJ:  raw = same_reg ? opa : {opb[63:31], opa[30:0]};
      OP_INJN: raw = {opa[63:32], ~(same_reg ? opa[31] : opb[31]), opa[30:0]};
      OP_INJX: raw = {opa[63:32], same_reg ? 1'b0 : (opa[31] ^ opb[31]), opa[30:0]};
      OP_I2F:  raw = {32'hFFFF_FFFF, src_a[31:0]};
      OP_F2I: begin
        raw = {{32{src_a[31]}}, src_a[31:0]};
        writes_fp = 1'b0;
      end
      default: writes_fp = 1'b0;
    endcase
  end

  assign result   = (int_mode && writes_fp) ? {{32{raw[31]}}, raw[31:0]} : raw;
  assign fp_dirty = writes_fp;

  always_comb begin
    if (op == OP_F2I) begin
      assert_f2i_sext_R8: assert (result[63:32] == {32{src_a[31]}} && result[31:0] == src_a[31:0])
        else $error("float-to-int move not sign-extended");
      assert_f2i_clean_R9: assert (!fp_dirty) else $error("dirty on move to integer register");
    end
    if (int_mode && op <= OP_I2F)
      assert_int_sext_R6: assert (result[63:32] == {32{result[31]}})
        else $error("integer mode result not sign-extended");
    if (!int_mode && op <= OP_I2F)
      assert_boxed_out_R1: assert (&result[63:32]) else $error("normal mode result not boxed");
    if (!int_mode && same_reg && op == OP_INJ && !(&src_a[63:32]))
      assert_nan_subst_R1: assert (result == QNAN_BOXED) else $error("unboxed operand not replaced");
    if (op > OP_F2I)
      assert_unused_op_R10: assert (result == '0 && !fp_dirty) else $error("unused op had effect");
  end
endmodule

// File: tb/fp_sign_move_test.sv
module fp_sign_move_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] src_a, src_b, result;
  logic [2:0]  op;
  logic        same_reg, int_mode, fp_dirty;
  int tests = 0, fails = 0;
  bit done = 0;

  fp_sign_move uut (.src_a(src_a), .src_b(src_b), .op(op), .same_reg(same_reg),
                    .int_mode(int_mode), .result(result), .fp_dirty(fp_dirty));

  task automatic apply(input logic [2:0] o, input logic s, input logic m,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op = o; same_reg = s; int_mode = m; src_a = a; src_b = b;
    #5;
  endtask

  task automatic chk(input string req, input logic [63:0] exp_r, input logic exp_d);
    tests++;
    if (result !== exp_r || fp_dirty !== exp_d) begin
      fails++;
      $display("FAIL %s: result=%h dirty=%b expected result=%h dirty=%b",
               req, result, fp_dirty, exp_r, exp_d);
    end
  endtask

  task automatic t_box_check_r1;
    apply(0, 0, 0, 64'h00000000_3F800000, 64'hFFFFFFFF_C0000000);
    chk("R1", 64'hFFFFFFFF_FFC00000, 1);
    apply(0, 0, 0, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFE_C0000000);
    chk("R1", 64'hFFFFFFFF_3F800000, 1);
    apply(1, 0, 0, 64'hFFFFFFFF_3F800000, 64'h7FFFFFFF_40000000);
    chk("R1", 64'hFFFFFFFF_BF800000, 1);
  endtask

  task automatic t_inject_r2;
    apply(0, 0, 0, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_C0000000);
    chk("R2", 64'hFFFFFFFF_BF800000, 1);
    apply(0, 0, 0, 64'hFFFFFFFF_C1200000, 64'hFFFFFFFF_40000000);
    chk("R2", 64'hFFFFFFFF_41200000, 1);
  endtask

  task automatic t_negate_r3;
    apply(1, 0, 0, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_C0000000);
    chk("R3", 64'hFFFFFFFF_3F800000, 1);
    apply(1, 0, 0, 64'hFFFFFFFF_C1200000, 64'hFFFFFFFF_40000000);
    chk("R3", 64'hFFFFFFFF_C1200000, 1);
  endtask

  task automatic t_xor_r4;
    apply(2, 0, 0, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_C0000000);
    chk("R4", 64'hFFFFFFFF_BF800000, 1);
    apply(2, 0, 0, 64'hFFFFFFFF_C1200000, 64'hFFFFFFFF_C0000000);
    chk("R4", 64'hFFFFFFFF_41200000, 1);
  endtask

  task automatic t_alias_r5;
    apply(0, 1, 0, 64'hFFFFFFFF_BF800000, 64'hFFFFFFFF_00000000);
    chk("R5", 64'hFFFFFFFF_BF800000, 1);
    apply(1, 1, 0, 64'hFFFFFFFF_BF800000, 64'hFFFFFFFF_80000000);
    chk("R5", 64'hFFFFFFFF_3F800000, 1);
    apply(2, 1, 0, 64'hFFFFFFFF_BF800000, 64'hFFFFFFFF_80000000);
    chk("R5", 64'hFFFFFFFF_3F800000, 1);
    apply(0, 1, 0, 64'h00000000_3F800000, 64'hFFFFFFFF_00000000);
    chk("R5", 64'hFFFFFFFF_7FC00000, 1);
  endtask

  task automatic t_int_mode_r6;
    apply(0, 0, 1, 64'h12345678_BF800000, 64'h00000000_00000000);
    chk("R6", 64'h00000000_3F800000, 1);
    apply(1, 0, 1, 64'h12345678_BF800000, 64'h00000000_00000000);
    chk("R6", 64'hFFFFFFFF_BF800000, 1);
    apply(2, 0, 1, 64'h12345678_BF800000, 64'h00000000_00000000);
    chk("R6", 64'hFFFFFFFF_BF800000, 1);
    apply(1, 1, 1, 64'h00000000_3F800000, 64'h0);
    chk("R6", 64'hFFFFFFFF_BF800000, 1);
    apply(3, 0, 1, 64'hABCDEF01_92345678, 64'h0);
    chk("R6", 64'hFFFFFFFF_92345678, 1);
    apply(3, 0, 1, 64'hABCDEF01_12345678, 64'h0);
    chk("R6", 64'h00000000_12345678, 1);
  endtask

  task automatic t_i2f_r7;
    apply(3, 0, 0, 64'hABCDEF01_12345678, 64'h0);
    chk("R7", 64'hFFFFFFFF_12345678, 1);
  endtask

  task automatic t_f2i_r8;
    apply(4, 0, 0, 64'hFFFFFFFF_80000001, 64'h0);
    chk("R8", 64'hFFFFFFFF_80000001, 0);
    apply(4, 0, 0, 64'h55555555_7FFFFFFF, 64'h0);
    chk("R8", 64'h00000000_7FFFFFFF, 0);
    apply(4, 0, 1, 64'h00000000_C0000000, 64'h0);
    chk("R8", 64'hFFFFFFFF_C0000000, 0);
  endtask

  task automatic t_dirty_r9;
    apply(4, 1, 0, 64'hFFFFFFFF_3F800000, 64'h0);
    chk("R9", 64'h00000000_3F800000, 0);
    apply(2, 1, 1, 64'h00000000_3F800000, 64'h0);
    chk("R9", 64'h00000000_3F800000, 1);
  endtask

  task automatic t_unused_r10;
    for (int k = 5; k < 8; k++) begin
      apply(3'(k), 0, 0, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_C0000000);
      chk("R10", 64'h0, 0);
    end
  endtask

  initial begin
    op = 0; same_reg = 0; int_mode = 0; src_a = 0; src_b = 0;
    t_box_check_r1();
    t_inject_r2();
    t_negate_r3();
    t_xor_r4();
    t_alias_r5();
    t_int_mode_r6();
    t_i2f_r7();
    t_f2i_r8();
    t_dirty_r9();
    t_unused_r10();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule